// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error Flags

This block turns an asynchronous serial input line into characters. It is timed by a baud tick that occurs sixteen times per bit period. The character length is configurable from five to eight data bits, and an even or odd parity bit is optional. Each finished character leaves the block as a single write beat toward an external receive FIFO. The beat carries the data byte and three error flags for that character: parity, framing and break.

A low level that has gone away by the middle of the start bit counts as noise and produces no character. If the line stays low through a whole character, including its stop bit, the block stores exactly one all-zero break record and then waits for the line to go high again. If the FIFO reports full when a character completes, the character is dropped and a one-cycle overrun pulse is raised. The FIFO itself is outside the block, and its contents are never touched.

The line-format settings are captured when a start edge is detected. They are held for the rest of that character, so the settings can be shared with a transmitter without disturbing a frame already in progress.

Top module: `serial_rx_deframer`

## Requirements
- R1: After reset, and on every cycle without a finished character, `fifo_wr` and `rx_overrun` are 0. A finished character gives exactly one of these: a single-cycle `fifo_wr` or a single-cycle `rx_overrun`.
- R2: `cfg_len` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. The first data bit received goes to `fifo_wdata[0]`, and data bits above the configured length are written as 0.
- R3: A start is detected on a tick where the synchronized line is low. The line is sampled again 8 ticks later. If it is high at that point, the start is discarded and no write or overrun results.
- R4: When `cfg_par_en` is 1, one parity bit follows the data bits. `fifo_wperr` is 1 exactly when the count of ones in the data and parity bits is odd under even parity (`cfg_par_odd`=0), or even under odd parity (`cfg_par_odd`=1). With parity disabled, `fifo_wperr` is 0.
- R5: `fifo_wferr` is 1 when the stop bit is sampled low.
- R6: When every data bit, the parity bit (if enabled) and the stop bit all sample low, one record is written with data 0, `fifo_wbrk`=1, `fifo_wferr`=1 and `fifo_wperr`=0. No further start is detected until the line samples high on a tick. A following normal character is then received correctly.
- R7: If `fifo_full` is 1 on the clock edge where the stop bit is sampled, there is no write and `rx_overrun` pulses for one cycle. Later characters are received normally once `fifo_full` is 0.
- R8: Each sampling point comes 16 ticks after the previous one. A tick acts on `rxd` as registered two clocks earlier. The write or overrun appears in the cycle right after the stop-bit sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable, 16 per bit period |
| rxd | input | 1 | Serial input line, idle high |
| cfg_len | input | 2 | Data bit count minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| fifo_full | input | 1 | Receive FIFO has no free entry |
| fifo_wr | output | 1 | Write strobe for one character record |
| fifo_wdata | output | 8 | Received character, first bit in bit 0 |
| fifo_wperr | output | 1 | Parity error flag for this record |
| fifo_wferr | output | 1 | Framing error flag for this record |
| fifo_wbrk | output | 1 | Break flag for this record |
| rx_overrun | output | 1 | One-cycle pulse: character dropped because the FIFO was full |

## Verification
Every result is due a fixed number of cycles after its cause. A tick reacts to a line level registered two clocks before that tick's edge. The write beat or overrun pulse appears one clock after the tick that samples the stop bit, and no other output changes between sampling points. The bench keeps its own behavioural model of the line timing. The model steps on the same rising edge as the design, using the same two-clock delay, and every output is compared with it at the following falling edge, so any change in a sampling point or in latency shows up as a mismatch in that exact cycle. Directed counts of writes and overruns after each stimulus confirm that false starts, breaks and full-FIFO drops have the expected effect.

// File: rtl/rx_pkg.sv
package rx_pkg;

  localparam int RX_DW   = 8;
  localparam int RX_IDXW = $clog2(RX_DW);

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_BRK
  } rx_state_e;

  // number of data bits for a length code (0..3 -> 5..8)
  function automatic logic [3:0] bits_for_len(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rx_sequencer.sv
module rx_sequencer
  import rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               rxd,
  input  logic [1:0]         cfg_len,
  input  logic               cfg_par_en,
  input  logic               cfg_par_odd,
  input  logic               all_zero,
  output logic               clr,
  output logic               data_stb,
  output logic               par_stb,
  output logic               stop_stb,
  output logic [RX_IDXW-1:0] bit_idx,
  output logic [1:0]         len_q,
  output logic               pen_q,
  output logic               podd_q
);

  localparam int          CW   = $clog2(OSR);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);

  rx_state_e            state_q, state_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [RX_IDXW-1:0]   idx_q, idx_d;
  logic [1:0]           len_d;
  logic                 pen_d, podd_d;
  logic                 last_tick;
  logic [3:0]           nbits;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    len_d     = len_q;
    pen_d     = pen_q;
    podd_d    = podd_q;
    clr       = 1'b0;
    data_stb  = 1'b0;
    par_stb   = 1'b0;
    stop_stb  = 1'b0;
    last_tick = (cnt_q == LAST);
    nbits     = bits_for_len(len_q);
    if (tick) begin
      unique case (state_q)
        RX_IDLE: begin
          if (!rxd) begin
            state_d = RX_START;
            cnt_d   = '0;
            clr     = 1'b1;
            len_d   = cfg_len;
            pen_d   = cfg_par_en;
            podd_d  = cfg_par_odd;
          end
        end
        RX_START: begin
          if (cnt_q == MID) begin
            cnt_d   = '0;
            idx_d   = '0;
            state_d = rxd ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (last_tick) begin
            cnt_d    = '0;
            data_stb = 1'b1;
            if ({1'b0, idx_q} == nbits - 4'd1) state_d = pen_q ? RX_PAR : RX_STOP;
            else                               idx_d   = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (last_tick) begin
            cnt_d   = '0;
            par_stb = 1'b1;
            state_d = RX_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (last_tick) begin
            cnt_d    = '0;
            stop_stb = 1'b1;
            state_d  = (!rxd && all_zero) ? RX_BRK : RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_BRK: begin
          if (rxd) state_d = RX_IDLE;
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      len_q   <= '0;
      pen_q   <= 1'b0;
      podd_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      len_q   <= len_d;
      pen_q   <= pen_d;
      podd_q  <= podd_d;
    end
  end

  assign bit_idx = idx_q;

  // R8: state only advances on a baud tick
  a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state_q) && $stable(cnt_q));

  // R3: a start that reads high at mid-bit returns to idle
  a_r3_false_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && tick && cnt_q == MID && rxd) |=> state_q == RX_IDLE);

  // R6: break state is left only on a high line sample
  a_r6_break_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_BRK && !(tick && rxd)) |=> state_q == RX_BRK);

endmodule

// File: rtl/rx_shifter.sv
module rx_shifter
  import rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               data_stb,
  input  logic               par_stb,
  input  logic [RX_IDXW-1:0] bit_idx,
  input  logic               rxd,
  output logic [RX_DW-1:0]   data_q,
  output logic               par_q,
  output logic               all_zero
);

  logic [RX_DW-1:0] data_d;
  logic             par_d;

  always_comb begin
    data_d = data_q;
    par_d  = par_q;
    if (clr) begin
      data_d = '0;
      par_d  = 1'b0;
    end else if (data_stb) begin
      data_d[bit_idx] = rxd;
    end else if (par_stb) begin
      par_d = rxd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      par_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      par_q  <= par_d;
    end
  end

  assign all_zero = (data_q == '0) && !par_q;

  // R2: a new frame starts from an empty byte
  a_r2_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> data_q == '0 && !par_q);

endmodule

// File: rtl/rx_writer.sv
module rx_writer
  import rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_stb,
  input  logic             rxd,
  input  logic [RX_DW-1:0] data_q,
  input  logic             par_q,
  input  logic             all_zero,
  input  logic             pen,
  input  logic             podd,
  input  logic             fifo_full,
  output logic             wr_en,
  output logic [RX_DW-1:0] wr_data,
  output logic             wr_perr,
  output logic             wr_ferr,
  output logic             wr_brk,
  output logic             ovf
);

  logic wr_d, ovf_d, brk_d, perr_d, ferr_d;

  always_comb begin
    brk_d  = !rxd && all_zero;
    ferr_d = !rxd;
    perr_d = pen && ((^data_q) ^ par_q ^ podd) && !brk_d;
    wr_d   = stop_stb && !fifo_full;
    ovf_d  = stop_stb && fifo_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      ovf     <= 1'b0;
      wr_data <= '0;
      wr_perr <= 1'b0;
      wr_ferr <= 1'b0;
      wr_brk  <= 1'b0;
    end else begin
      wr_en <= wr_d;
      ovf   <= ovf_d;
      if (wr_d) begin
        wr_data <= data_q;
        wr_perr <= perr_d;
        wr_ferr <= ferr_d;
        wr_brk  <= brk_d;
      end
    end
  end

  // R1: a finished character is either written or dropped, never both
  a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, ovf}));

  // R7: a full FIFO blocks the write and raises overrun
  a_r7_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_stb && fifo_full) |=> !wr_en && ovf);

  // R6: break records carry zero data and a framing flag
  a_r6_break_record: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_brk) |-> (wr_data == '0) && wr_ferr && !wr_perr);

endmodule

// File: rtl/serial_rx_deframer.sv
module serial_rx_deframer
  import rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       fifo_full,
  output logic       fifo_wr,
  output logic [7:0] fifo_wdata,
  output logic       fifo_wperr,
  output logic       fifo_wferr,
  output logic       fifo_wbrk,
  output logic       rx_overrun
);

  logic               rxd_s;
  logic               clr, data_stb, par_stb, stop_stb;
  logic [RX_IDXW-1:0] bit_idx;
  logic [1:0]         len_q;
  logic               pen_q, podd_q;
  logic [RX_DW-1:0]   data_q;
  logic               par_q, all_zero;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
  );

  rx_sequencer #(.OSR(OSR)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd_s),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .all_zero(all_zero), .clr(clr), .data_stb(data_stb), .par_stb(par_stb),
    .stop_stb(stop_stb), .bit_idx(bit_idx), .len_q(len_q), .pen_q(pen_q),
    .podd_q(podd_q)
  );

  rx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr), .data_stb(data_stb), .par_stb(par_stb),
    .bit_idx(bit_idx), .rxd(rxd_s), .data_q(data_q), .par_q(par_q),
    .all_zero(all_zero)
  );

  rx_writer u_wr (
    .clk(clk), .rst_n(rst_n), .stop_stb(stop_stb), .rxd(rxd_s), .data_q(data_q),
    .par_q(par_q), .all_zero(all_zero), .pen(pen_q), .podd(podd_q),
    .fifo_full(fifo_full), .wr_en(fifo_wr), .wr_data(fifo_wdata),
    .wr_perr(fifo_wperr), .wr_ferr(fifo_wferr), .wr_brk(fifo_wbrk),
    .ovf(rx_overrun)
  );

  // R2: bits above the captured length are zero in every record
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (fifo_wdata >> bits_for_len(len_q)) == 8'd0);

  // R4: no parity flag when the frame carried no parity bit
  a_r4_no_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && !pen_q) |-> !fifo_wperr);

endmodule

// File: tb/tb_serial_rx_deframer.sv
`timescale 1ns/1ps
module tb_serial_rx_deframer;

  localparam int TDIV   = 2;
  localparam int BITCLK = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick;
  logic       rxd;
  logic [1:0] cfg_len;
  logic       cfg_par_en, cfg_par_odd, fifo_full;
  logic       fifo_wr, fifo_wperr, fifo_wferr, fifo_wbrk, rx_overrun;
  logic [7:0] fifo_wdata;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  serial_rx_deframer dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .fifo_wperr(fifo_wperr), .fifo_wferr(fifo_wferr), .fifo_wbrk(fifo_wbrk),
    .rx_overrun(rx_overrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // baud tick: one cycle in every TDIV, driven at the falling edge
  int tdiv_cnt = 0;
  always @(negedge clk) begin
    baud_tick <= (tdiv_cnt == 0);
    tdiv_cnt  <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
  end

  // ---------------- behavioural reference model ----------------
  int         m_state;            // 0 idle 1 start 2 data 3 parity 4 stop 5 break
  int         m_cnt, m_bit, m_nb;
  bit         m_pen, m_podd, m_par;
  logic [7:0] m_data;
  logic       h1, h2, vd;
  bit         e_wr, e_ovf, e_perr, e_ferr, e_brk;
  logic [7:0] e_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_bit = 0; m_nb = 8; m_pen = 0; m_podd = 0;
      m_par = 0; m_data = 0; h1 = 1; h2 = 1; e_wr = 0; e_ovf = 0;
      e_perr = 0; e_ferr = 0; e_brk = 0; e_data = 0;
    end else begin
      vd = h2; h2 = h1; h1 = rxd;           // two-clock line delay (R8)
      e_wr = 0; e_ovf = 0;
      if (baud_tick) begin
        case (m_state)
          0: if (!vd) begin
               m_state = 1; m_cnt = 0; m_data = 0; m_par = 0;
               m_nb = 5 + cfg_len; m_pen = cfg_par_en; m_podd = cfg_par_odd;
             end
          1: begin
               m_cnt++;
               if (m_cnt == 8) begin
                 m_cnt = 0; m_bit = 0;
                 m_state = vd ? 0 : 2;
               end
             end
          2: begin
               m_cnt++;
               if (m_cnt == 16) begin
                 m_cnt = 0;
                 m_data[m_bit] = vd;
                 m_bit++;
                 if (m_bit == m_nb) m_state = m_pen ? 3 : 4;
               end
             end
          3: begin
               m_cnt++;
               if (m_cnt == 16) begin m_cnt = 0; m_par = vd; m_state = 4; end
             end
          4: begin
               m_cnt++;
               if (m_cnt == 16) begin
                 bit z, b;
                 m_cnt = 0;
                 z = (m_data == 0) && !m_par;
                 b = !vd && z;
                 if (fifo_full) e_ovf = 1;
                 else begin
                   e_wr   = 1;
                   e_data = m_data;
                   e_brk  = b;
                   e_ferr = !vd;
                   e_perr = m_pen && ((^m_data) ^ m_par ^ m_podd) && !b;
                 end
                 m_state = b ? 5 : 0;
               end
             end
          default: if (vd) m_state = 0;
        endcase
      end
    end
  end

  // ---------------- per-cycle comparison and capture ----------------
  int         wr_cnt = 0, ovf_cnt = 0;
  logic [7:0] last_data;
  bit         last_perr, last_ferr, last_brk;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 R8 write strobe timing", fifo_wr, e_wr);
      chk("R7 R8 overrun timing", rx_overrun, e_ovf);
      if (e_wr && fifo_wr) begin
        chk("R2 data", fifo_wdata, e_data);
        chk("R4 parity flag", fifo_wperr, e_perr);
        chk("R5 framing flag", fifo_wferr, e_ferr);
        chk("R6 break flag", fifo_wbrk, e_brk);
      end
      if (fifo_wr) begin
        wr_cnt++;
        last_data = fifo_wdata; last_perr = fifo_wperr;
        last_ferr = fifo_wferr; last_brk = fifo_wbrk;
      end
      if (rx_overrun) ovf_cnt++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic hold(input logic lvl, input int clocks);
    rxd = lvl;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] v, input int nb, input bit pen, input bit podd,
                      input bit bad_par, input bit stop_low);
    logic [7:0] m;
    m = v & 8'((1 << nb) - 1);
    hold(1'b0, BITCLK);
    for (int i = 0; i < nb; i++) hold(m[i], BITCLK);
    if (pen) hold((^m) ^ podd ^ bad_par, BITCLK);
    if (stop_low) hold(1'b0, 12 * TDIV);
    else          hold(1'b1, BITCLK);
    hold(1'b1, 3 * BITCLK);
  endtask

  task automatic expect_char(input string tag, input int n0, input logic [7:0] d,
                             input bit pe, input bit fe, input bit br);
    chk({tag, " write count"}, wr_cnt, n0 + 1);
    chk({tag, " data"}, last_data, d);
    chk({tag, " flags"}, {last_perr, last_ferr, last_brk}, {pe, fe, br});
  endtask

  initial begin
    int n0, o0;
    rst_n = 0; rxd = 1; fifo_full = 0;
    cfg_len = 2'd3; cfg_par_en = 0; cfg_par_odd = 0;
    repeat (5) @(negedge clk);
    chk("R1 reset write", fifo_wr, 0);
    chk("R1 reset overrun", rx_overrun, 0);
    rst_n = 1;
    hold(1'b1, 2 * BITCLK);

    // R2: 8 bits, LSB first
    n0 = wr_cnt; send(8'hA5, 8, 0, 0, 0, 0);
    expect_char("R2 8-bit", n0, 8'hA5, 0, 0, 0);

    // R2: 5 bits, upper bits zero
    cfg_len = 2'd0;
    n0 = wr_cnt; send(8'hF6, 5, 0, 0, 0, 0);
    expect_char("R2 5-bit", n0, 8'h16, 0, 0, 0);

    // R2: 6 bits
    cfg_len = 2'd1;
    n0 = wr_cnt; send(8'h2B, 6, 0, 0, 0, 0);
    expect_char("R2 6-bit", n0, 8'h2B, 0, 0, 0);

    // R4: 7 bits even parity, good then bad
    cfg_len = 2'd2; cfg_par_en = 1; cfg_par_odd = 0;
    n0 = wr_cnt; send(8'h55, 7, 1, 0, 0, 0);
    expect_char("R4 even good", n0, 8'h55, 0, 0, 0);
    n0 = wr_cnt; send(8'h13, 7, 1, 0, 1, 0);
    expect_char("R4 even bad", n0, 8'h13, 1, 0, 0);

    // R4: 8 bits odd parity, good then bad
    cfg_len = 2'd3; cfg_par_odd = 1;
    n0 = wr_cnt; send(8'h0F, 8, 1, 1, 0, 0);
    expect_char("R4 odd good", n0, 8'h0F, 0, 0, 0);
    n0 = wr_cnt; send(8'hC1, 8, 1, 1, 1, 0);
    expect_char("R4 odd bad", n0, 8'hC1, 1, 0, 0);

    // R5: stop bit low with nonzero data
    cfg_par_en = 0; cfg_par_odd = 0;
    n0 = wr_cnt; send(8'h3C, 8, 0, 0, 0, 1);
    expect_char("R5 framing", n0, 8'h3C, 0, 1, 0);

    // R3: short low glitch is not a start
    n0 = wr_cnt; o0 = ovf_cnt;
    hold(1'b0, 4 * TDIV);
    hold(1'b1, 4 * BITCLK);
    chk("R3 glitch no write", wr_cnt, n0);
    chk("R3 glitch no overrun", ovf_cnt, o0);

    // R6: long low line gives a single break record, then recovery
    n0 = wr_cnt;
    hold(1'b0, 30 * BITCLK);
    chk("R6 break single record", wr_cnt, n0 + 1);
    chk("R6 break record", {last_data, last_perr, last_ferr, last_brk}, {8'h00, 3'b011});
    hold(1'b1, 2 * BITCLK);
    n0 = wr_cnt; send(8'h81, 8, 0, 0, 0, 0);
    expect_char("R6 after break", n0, 8'h81, 0, 0, 0);

    // R7: full FIFO drops the character
    fifo_full = 1;
    n0 = wr_cnt; o0 = ovf_cnt; send(8'h77, 8, 0, 0, 0, 0);
    chk("R7 no write while full", wr_cnt, n0);
    chk("R7 overrun pulse", ovf_cnt, o0 + 1);
    fifo_full = 0;
    n0 = wr_cnt; send(8'h42, 8, 0, 0, 0, 0);
    expect_char("R7 after overrun", n0, 8'h42, 0, 0, 0);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    finish_run();
  end

endmodule